// File: doc/BRIEF.md
# Missing and Total Transverse Energy Summer

This block takes the transverse-energy sums of the 18 azimuthal strips of a calorimeter, one strip per valid beat, and reduces them to three event-level quantities. The strips are 20 degrees wide, which is coarser than the 5-degree tower grid. Each strip energy is projected onto the x and y axes with fixed sine and cosine coefficients for the centre of that strip. The block keeps a saturating scalar total and two signed vector sums. When the last strip of a frame has been taken in, it reports the total energy, the magnitude of the missing transverse energy and the strip direction the missing energy points to.

One energy LSB stands for roughly 1 GeV. The magnitude comes from a sequential integer square root of Ex²+Ey², with no divider and no multiplier in the loop. Its latency is fixed, so the results and a one-cycle done pulse appear a known number of cycles after the last strip. A new frame may begin while the root of the previous frame is still being computed. Strips must arrive in index order. Any deviation aborts the frame and raises a sticky error flag.

Top module: `et_balance_summer`

## Requirements
- R1: While reset is high, and after reset until the first result, out_done, out_tot, out_met, out_phi and seq_err are all zero.
- R2: out_tot is the sum of the 18 strip energies of a frame, saturating at 16383 (all ones in 14 bits).
- R3: For strip k (centre at 10+20k degrees), the x and y contributions are floor(E·C/512) and floor(E·S/512). C and S are round(512·cos) and round(512·sin) of the centre angle, clamped to ±511. out_met is floor(sqrt(Ex²+Ey²)) of the frame's summed contributions.
- R4: out_phi is the index k that maximises −(Ex·C_k + Ey·S_k). On ties the lowest index wins, so a perfectly balanced frame gives 0.
- R5: out_done is high for exactly one cycle, 18 clock edges after the edge that accepts strip 17 (the accepting edge counts as the first). out_tot, out_met and out_phi change only on that edge and hold their values otherwise.
- R6: Cycles with in_valid low have no effect, whatever in_idx and in_et carry.
- R7: A frame begins with a valid beat of index 0 and must continue with indices 1 to 17 in order. Any other valid index sets seq_err, which stays set until reset. That beat aborts the frame, no result is produced for it, and the next frame must start again at index 0 and then completes normally.
- R8: A new frame may start on the cycle right after strip 17 of the previous frame. Both frames produce correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strip beat present |
| in_idx | input | 5 | Strip index, 0 to 17 |
| in_et | input | 10 | Unsigned strip transverse energy |
| out_done | output | 1 | One-cycle pulse when a frame's results update |
| out_tot | output | 14 | Saturated total transverse energy |
| out_met | output | 16 | Missing transverse energy magnitude |
| out_phi | output | 5 | Strip index of the missing-energy direction |
| seq_err | output | 1 | Sticky strip-order error |

## Verification
A wrong coefficient or a mis-rounded projection corrupts the vector sums. It shows up in out_met, and usually in out_phi, in the done cycle of the very frame that used that strip, so every frame is compared in full the moment it completes. A stuck or miscounted root iteration moves or loses the done pulse, and a lost frame index suppresses the pulse or raises seq_err early. Both are caught on the exact cycle, because done, the held outputs and the error flag are compared against the model on every clock. Results that drift between pulses are caught on the first cycle they move.

// File: rtl/met_pkg.sv
package met_pkg;

    localparam int N_STRIPS  = 18;
    localparam int ET_W      = 10;
    localparam int COEF_W    = 10;
    localparam int COEF_FRAC = 9;
    localparam int ACC_W     = 16;
    localparam int TOT_W     = 14;
    localparam int IDX_W     = $clog2(N_STRIPS);
    localparam int RAD_W     = 2 * ACC_W;
    localparam int SQ_STEPS  = RAD_W / 2;
    localparam int LATENCY   = SQ_STEPS + 1;
    localparam int PROD_W    = ET_W + 1 + COEF_W;
    localparam int DIR_W     = ACC_W + COEF_W + 2;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  vec_t;
    typedef logic [TOT_W-1:0]         tot_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic [ET_W-1:0]          et_t;

    typedef struct packed {
        tot_t tot;
        vec_t ex;
        vec_t ey;
    } frame_sum_t;

    // cos of strip centre (10 + 20k degrees), scaled by 2^COEF_FRAC
    function automatic coef_t cos_coef(input int k);
        case (k)
            0, 17:  return coef_t'(504);
            1, 16:  return coef_t'(443);
            2, 15:  return coef_t'(329);
            3, 14:  return coef_t'(175);
            5, 12:  return coef_t'(-175);
            6, 11:  return coef_t'(-329);
            7, 10:  return coef_t'(-443);
            8, 9:   return coef_t'(-504);
            default: return coef_t'(0);
        endcase
    endfunction

    // sin of strip centre, same scaling
    function automatic coef_t sin_coef(input int k);
        case (k)
            0, 8:   return coef_t'(89);
            1, 7:   return coef_t'(256);
            2, 6:   return coef_t'(392);
            3, 5:   return coef_t'(481);
            4:      return coef_t'(511);
            9, 17:  return coef_t'(-89);
            10, 16: return coef_t'(-256);
            11, 15: return coef_t'(-392);
            12, 14: return coef_t'(-481);
            13:     return coef_t'(-511);
            default: return coef_t'(0);
        endcase
    endfunction

    function automatic tot_t sat_add(input tot_t a, input et_t b);
        logic [TOT_W:0] s;
        s = {1'b0, a} + (TOT_W+1)'(b);
        return s[TOT_W] ? '1 : s[TOT_W-1:0];
    endfunction

endpackage

// File: rtl/met_strip_project.sv
module met_strip_project
    import met_pkg::*;
(
    input  et_t  et,
    input  idx_t idx,
    output vec_t px,
    output vec_t py
);
    coef_t c_cos, c_sin;
    logic signed [PROD_W-1:0] e_s, prod_x, prod_y, shx, shy;

    always_comb begin
        c_cos  = cos_coef(int'(idx));
        c_sin  = sin_coef(int'(idx));
        e_s    = PROD_W'($signed({1'b0, et}));
        prod_x = e_s * PROD_W'(c_cos);
        prod_y = e_s * PROD_W'(c_sin);
        shx    = prod_x >>> COEF_FRAC;
        shy    = prod_y >>> COEF_FRAC;
        px     = shx[ACC_W-1:0];
        py     = shy[ACC_W-1:0];
    end
endmodule

// File: rtl/met_frame_accum.sv
module met_frame_accum
    import met_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  idx_t       in_idx,
    input  et_t        in_et,
    output logic       fire,
    output frame_sum_t sum_q,
    output idx_t       exp_idx,
    output logic       err
);
    vec_t px, py;
    tot_t acc_tot;
    vec_t acc_ex, acc_ey;
    logic hit, first, last;
    frame_sum_t nxt;

    met_strip_project u_proj (
        .et  (in_et),
        .idx (in_idx),
        .px  (px),
        .py  (py)
    );

    always_comb begin
        hit     = in_valid && (in_idx == exp_idx);
        first   = (exp_idx == '0);
        last    = (in_idx == idx_t'(N_STRIPS - 1));
        nxt.tot = sat_add(first ? tot_t'(0) : acc_tot, in_et);
        nxt.ex  = (first ? vec_t'(0) : acc_ex) + px;
        nxt.ey  = (first ? vec_t'(0) : acc_ey) + py;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire    <= 1'b0;
            sum_q   <= '0;
            exp_idx <= '0;
            err     <= 1'b0;
            acc_tot <= '0;
            acc_ex  <= '0;
            acc_ey  <= '0;
        end else begin
            fire <= 1'b0;
            if (hit) begin
                if (last) begin
                    sum_q   <= nxt;
                    fire    <= 1'b1;
                    exp_idx <= '0;
                end else begin
                    acc_tot <= nxt.tot;
                    acc_ex  <= nxt.ex;
                    acc_ey  <= nxt.ey;
                    exp_idx <= exp_idx + idx_t'(1);
                end
            end else if (in_valid) begin
                err     <= 1'b1;
                exp_idx <= '0;
            end
        end
    end
endmodule

// File: rtl/met_isqrt.sv
module met_isqrt
    import met_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [RAD_W-1:0] rad,
    output logic [ACC_W-1:0] root,
    output logic             done,
    output logic             finishing
);
    localparam int CNT_W = $clog2(SQ_STEPS);

    logic [RAD_W-1:0] op, acc, one;
    logic [RAD_W-1:0] trial, op_n, acc_n;
    logic [CNT_W-1:0] cnt;
    logic             run, ge;

    always_comb begin
        trial     = acc + one;
        ge        = (op >= trial);
        op_n      = ge ? (op - trial) : op;
        acc_n     = ge ? ((acc >> 1) + one) : (acc >> 1);
        finishing = run && (cnt == CNT_W'(SQ_STEPS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op   <= '0;
            acc  <= '0;
            one  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            root <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                op  <= rad;
                acc <= '0;
                one <= RAD_W'(1) << (RAD_W - 2);
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                op  <= op_n;
                acc <= acc_n;
                one <= one >> 2;
                cnt <= cnt + CNT_W'(1);
                if (finishing) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                    root <= acc_n[ACC_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/met_phi_select.sv
module met_phi_select
    import met_pkg::*;
(
    input  vec_t ex,
    input  vec_t ey,
    output idx_t phi
);
    logic signed [DIR_W-1:0] exw, eyw, best;
    logic signed [DIR_W-1:0] proj [N_STRIPS];

    assign exw = DIR_W'(ex);
    assign eyw = DIR_W'(ey);

    for (genvar k = 0; k < N_STRIPS; k++) begin : g_dir
        logic signed [DIR_W-1:0] cw, sw;
        assign cw      = DIR_W'(cos_coef(k));
        assign sw      = DIR_W'(sin_coef(k));
        assign proj[k] = -((exw * cw) + (eyw * sw));
    end

    always_comb begin
        best = proj[0];
        phi  = '0;
        for (int k = 1; k < N_STRIPS; k++) begin
            if (proj[k] > best) begin
                best = proj[k];
                phi  = idx_t'(k);
            end
        end
    end
endmodule

// File: rtl/et_balance_summer.sv
module et_balance_summer
    import met_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [ET_W-1:0]  in_et,
    output logic             out_done,
    output logic [TOT_W-1:0] out_tot,
    output logic [ACC_W-1:0] out_met,
    output logic [IDX_W-1:0] out_phi,
    output logic             seq_err
);
    logic                    acc_fire;
    frame_sum_t              acc_sum;
    idx_t                    acc_exp;
    logic signed [RAD_W-1:0] sq_x, sq_y;
    logic [RAD_W-1:0]        rad;
    logic                    sq_last;
    idx_t                    phi_c;

    met_frame_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_idx   (in_idx),
        .in_et    (in_et),
        .fire     (acc_fire),
        .sum_q    (acc_sum),
        .exp_idx  (acc_exp),
        .err      (seq_err)
    );

    assign sq_x = RAD_W'(acc_sum.ex) * RAD_W'(acc_sum.ex);
    assign sq_y = RAD_W'(acc_sum.ey) * RAD_W'(acc_sum.ey);
    assign rad  = $unsigned(sq_x) + $unsigned(sq_y);

    met_isqrt u_sqrt (
        .clk       (clk),
        .rst       (rst),
        .start     (acc_fire),
        .rad       (rad),
        .root      (out_met),
        .done      (out_done),
        .finishing (sq_last)
    );

    met_phi_select u_phi (
        .ex  (acc_sum.ex),
        .ey  (acc_sum.ey),
        .phi (phi_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_tot <= '0;
            out_phi <= '0;
        end else if (sq_last) begin
            out_tot <= acc_sum.tot;
            out_phi <= phi_c;
        end
    end
endmodule

// File: rtl/et_balance_summer_chk.sv
module et_balance_summer_chk
    import met_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_done,
    input logic             seq_err,
    input logic             fire,
    input logic [IDX_W-1:0] out_phi,
    input logic [IDX_W-1:0] exp_idx,
    input logic [ACC_W-1:0] out_met,
    input logic [TOT_W-1:0] out_tot
);
    localparam int CW = $clog2(LATENCY + 1);
    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)                         since <= '0;
        else if (fire)                   since <= CW'(1);
        else if (since == CW'(LATENCY))  since <= '0;
        else if (since != '0)            since <= since + CW'(1);
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);
    assert_done_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (since == CW'(LATENCY)));
    assert_done_due_R5: assert property (@(posedge clk) disable iff (rst)
        (since == CW'(LATENCY)) |-> out_done);
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_met) && $stable(out_tot) && $stable(out_phi)));
    assert_phi_range_R4: assert property (@(posedge clk) disable iff (rst)
        out_phi < IDX_W'(N_STRIPS));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(exp_idx));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> $past(in_valid));
endmodule

bind et_balance_summer et_balance_summer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_done (out_done),
    .seq_err  (seq_err),
    .fire     (acc_fire),
    .out_phi  (out_phi),
    .exp_idx  (acc_exp),
    .out_met  (out_met),
    .out_tot  (out_tot)
);

// File: tb/et_balance_summer_tb.sv
module et_balance_summer_tb;
    import met_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IDX_W-1:0] in_idx = '0;
    logic [ET_W-1:0]  in_et = '0;
    logic             out_done, seq_err;
    logic [TOT_W-1:0] out_tot;
    logic [ACC_W-1:0] out_met;
    logic [IDX_W-1:0] out_phi;

    et_balance_summer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx), .in_et(in_et),
        .out_done(out_done), .out_tot(out_tot), .out_met(out_met),
        .out_phi(out_phi), .seq_err(seq_err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    // reference model state
    int m_exp = 0, m_tot = 0, m_ex = 0, m_ey = 0;
    bit m_err = 1'b0;
    int q_due[$], q_tot[$], q_met[$], q_phi[$];
    int last_tot = 0, last_met = 0, last_phi = 0;
    int pat[18];
    logic [15:0] lfsr = 16'hACE1;

    function automatic int cf(int k, bit use_sin);
        real a, v;
        int r;
        a = (10.0 + 20.0 * k) * 3.14159265358979 / 180.0;
        v = (use_sin ? $sin(a) : $cos(a)) * 512.0;
        r = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
        if (r > 511) r = 511;
        if (r < -511) r = -511;
        return r;
    endfunction

    function automatic int isq(longint x);
        longint r;
        r = longint'($sqrt(real'(x)));
        while (r * r > x) r--;
        while ((r + 1) * (r + 1) <= x) r++;
        return int'(r);
    endfunction

    function automatic int pick_phi(int ex, int ey);
        longint best, p;
        int bi;
        best = -(longint'(ex) * cf(0, 0) + longint'(ey) * cf(0, 1));
        bi = 0;
        for (int k = 1; k < 18; k++) begin
            p = -(longint'(ex) * cf(k, 0) + longint'(ey) * cf(k, 1));
            if (p > best) begin best = p; bi = k; end
        end
        return bi;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic beat(int idx, int e);
        int c;
        @(negedge clk);
        c = cyc;
        in_valid = 1'b1;
        in_idx   = idx[IDX_W-1:0];
        in_et    = e[ET_W-1:0];
        if (idx == m_exp) begin
            if (m_exp == 0) begin m_tot = 0; m_ex = 0; m_ey = 0; end
            m_tot = (m_tot + e > 16383) ? 16383 : m_tot + e;
            m_ex  = m_ex + ((e * cf(idx, 0)) >>> 9);
            m_ey  = m_ey + ((e * cf(idx, 1)) >>> 9);
            if (idx == 17) begin
                q_due.push_back(c + 18);
                q_tot.push_back(m_tot);
                q_met.push_back(isq(longint'(m_ex) * m_ex + longint'(m_ey) * m_ey));
                q_phi.push_back(pick_phi(m_ex, m_ey));
                m_exp = 0;
            end else begin
                m_exp = idx + 1;
            end
        end else begin
            m_err = 1'b1;
            m_exp = 0;
        end
    endtask

    // R6: idle cycles carry garbage that must be ignored
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_idx   = IDX_W'(i % 18);
            in_et    = ET_W'(37 * i + 5);
        end
    endtask

    task automatic send_frame(int gap);
        for (int k = 0; k < 18; k++) begin
            beat(k, pat[k]);
            if (gap > 0 && (k % 3) == 1) idle(gap);
        end
    endtask

    task automatic fill_random();
        for (int k = 0; k < 18; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pat[k] = int'(lfsr) % 1024;
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        bit exp_done;
        #1;
        if (!rst && !finished) begin
            exp_done = (q_due.size() > 0) && (q_due[0] == cyc);
            check(out_done == exp_done, "R5", "done pulse", int'(out_done), int'(exp_done));
            if (exp_done) begin
                last_tot = q_tot.pop_front();
                last_met = q_met.pop_front();
                last_phi = q_phi.pop_front();
                void'(q_due.pop_front());
                check(int'(out_tot) == last_tot, "R2", "total", int'(out_tot), last_tot);
                check(int'(out_met) == last_met, "R3", "missing magnitude", int'(out_met), last_met);
                check(int'(out_phi) == last_phi, "R4", "direction", int'(out_phi), last_phi);
            end else begin
                check(int'(out_tot) == last_tot && int'(out_met) == last_met &&
                      int'(out_phi) == last_phi, "R5", "held result (met)",
                      int'(out_met), last_met);
            end
            check(seq_err == m_err, "R7", "sticky error", int'(seq_err), int'(m_err));
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_done == 1'b0 && out_tot == '0 && out_met == '0 && out_phi == '0,
              "R1", "outputs in reset", int'(out_met) + int'(out_tot), 0);
        check(seq_err == 1'b0, "R1", "error flag in reset", int'(seq_err), 0);
        rst = 1'b0;
        idle(3);
        check(out_tot == '0 && out_met == '0 && out_phi == '0 && !seq_err,
              "R1", "outputs after reset", int'(out_tot), 0);

        // R4 balanced: all zero
        for (int k = 0; k < 18; k++) pat[k] = 0;
        send_frame(0);
        idle(22);

        // R3 R4: one strip lit
        for (int k = 0; k < 18; k++) pat[k] = 0;
        pat[3] = 500;
        send_frame(0);
        idle(22);

        // R2 saturation: every strip at full scale
        for (int k = 0; k < 18; k++) pat[k] = 1023;
        send_frame(0);
        idle(22);

        // R3 R4: one half of the ring lit
        for (int k = 0; k < 18; k++) pat[k] = (k < 9) ? 1023 : 0;
        send_frame(0);
        idle(22);

        // R6: random frame with idle gaps inside it
        fill_random();
        send_frame(2);
        idle(22);

        // R8: back-to-back frames, the second starts during the root of the first
        fill_random();
        send_frame(0);
        fill_random();
        send_frame(0);
        for (int k = 0; k < 18; k++) pat[k] = 17 * k + 3;
        send_frame(0);
        idle(24);

        // R7: out-of-order index aborts the frame
        beat(0, 100);
        beat(1, 200);
        beat(2, 300);
        beat(5, 400);
        idle(24);
        beat(3, 50);      // non-zero start from idle is also rejected
        idle(4);
        fill_random();
        send_frame(0);    // R7: recovery frame still completes
        idle(24);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule